// File: doc/BRIEF.md
# Monochrome Shade Mapper

This block sits between the pixel pipeline of a four-shade display controller and the processor's register bus. It holds three 8-bit palette registers: one for the background layer and two for the object layer. Each register assigns one of four grey levels to each of the four 2-bit color indices. Every cycle the block turns a background color index and an object color index into one 2-bit shade code for the display. A select input chooses which object palette applies. An object index of zero counts as transparent, and the background shade then passes through.

The display fetches pixels eight at a time, one tile per fetch. The mapper therefore does not read the live registers when it produces a pixel. It copies all three palettes into a working set on the cycle a tile fetch finishes, and the lookup reads only that copy. A processor write lands at the end of its machine cycle. A tile whose fetch finishes in that same cycle still gets the old palette. Only tiles fetched afterwards see the new one. Software can therefore change shades partway through a line, and the change takes effect on an exact tile boundary.

Top module: `palette_map`

## Requirements
- R1: While `rst_n` is low at a clock edge, all three palette registers and the working copy are cleared to 0x00. After reset, every register reads 0x00 and `shade` is 0.
- R2: A write with `cpu_wr` high updates one register at that clock edge. Address 0xFF47 selects the background register, 0xFF48 object palette 0 and 0xFF49 object palette 1. While `cpu_addr` holds one of these addresses, `cpu_rdata` returns that register's current value, and reading has no side effects.
- R3: A write to any address outside 0xFF47..0xFF49 changes no register and no shade.
- R4: Within a palette, bits 1:0 give the shade for color index 0, bits 3:2 for index 1, bits 5:4 for index 2 and bits 7:6 for index 3. The shade codes are 0 white, 1 light grey, 2 dark grey and 3 black.
- R5: `shade` is computed only from the working copy. A register write is not visible at `shade` until a later cycle with `fetch_done` high.
- R6: When `fetch_done` and a write arrive in the same cycle, the working copy takes the register values from before that write. The new value appears only after the next `fetch_done`.
- R7: When `obj_idx` is 0, `obj_vis` is low and `shade` is the background shade for `bg_idx`, whatever field 0 of the object palettes holds.
- R8: When `obj_idx` is not 0, `obj_vis` is high and `shade` is the field for `obj_idx` in object palette 0 if `obj_pal_sel` is 0, or object palette 1 if it is 1.
- R9: While `cpu_addr` is outside 0xFF47..0xFF49, `cpu_rdata` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_wr | input | 1 | Register write strobe; the write lands at the end of this cycle |
| cpu_addr | input | 16 | Register bus address |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data for the addressed palette, 0 if unmapped |
| fetch_done | input | 1 | A tile fetch finishes this cycle; capture the palettes |
| bg_idx | input | 2 | Background color index |
| obj_idx | input | 2 | Object color index, 0 meaning transparent |
| obj_pal_sel | input | 1 | Object palette select (0 or 1) |
| shade | output | 2 | Final shade code for the display |
| obj_vis | output | 1 | High when the object pixel is opaque |

## Verification
Assertions check three things on every cycle. A fetch loads exactly the pre-edge register values, even when a write arrives in the same cycle. An unmapped write leaves the registers untouched. With no fetch and unchanged indices, the shade holds still. Readback after a write, unmapped reads and reset clearing are asserted as well. Only the bench's scenarios can show the rest. These are the full field-to-shade mapping of every index under different palettes, the transparent-index fallback with a nonzero object field 0, and the exact tile at which a mid-line write first appears.

// File: rtl/palette_map_pkg.sv
// Shared constants and types for the shade mapper.
// Assumes four colors per palette and palettes at consecutive addresses.
package palette_map_pkg;
    localparam int SHADE_W = 2;
    localparam int COLORS  = 1 << SHADE_W;
    localparam int PAL_W   = SHADE_W * COLORS;
    localparam int NUM_PAL = 3;

    // Palette slots; the order follows the address order
    typedef enum logic [1:0] {
        SLOT_BG  = 2'd0,
        SLOT_OB0 = 2'd1,
        SLOT_OB1 = 2'd2
    } pal_slot_e;

    typedef logic [NUM_PAL-1:0][PAL_W-1:0] pal_set_t;
    typedef logic [SHADE_W-1:0]            shade_t;

    // Pick the shade field for a color index out of one palette
    function automatic shade_t field_of(input logic [PAL_W-1:0] pal, input logic [SHADE_W-1:0] idx);
        return pal[idx*SHADE_W +: SHADE_W];
    endfunction
endpackage

// File: rtl/pal_regs.sv
// Palette register file: NUM_PAL byte registers at BASE_ADDR upward.
// Writes land at the clock edge ending the strobe cycle; reads are combinational.
module pal_regs
    import palette_map_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter logic [15:0] BASE_ADDR = 16'hFF47
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [PAL_W-1:0]  wdata,
    output logic [PAL_W-1:0]  rdata,
    output pal_set_t          pal_q
);
    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(BASE_ADDR);

    logic [NUM_PAL-1:0] hit;

    // One decoder per register slot
    for (genvar g = 0; g < NUM_PAL; g++) begin : g_dec
        assign hit[g] = (addr == BASE + ADDR_W'(g));
    end

    // Register update on a decoded write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pal_q <= '0;
        end else if (wr) begin
            for (int i = 0; i < NUM_PAL; i++) begin
                if (hit[i]) pal_q[i] <= wdata;
            end
        end
    end

    // Readback mux; zero when no slot is addressed
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_PAL; i++) begin
            if (hit[i]) rdata = rdata | pal_q[i];
        end
    end
endmodule

// File: rtl/pal_snap.sv
// Working copy of all palettes, loaded when a tile fetch completes.
// Samples the pre-edge register values, so a same-cycle write is not seen.
module pal_snap
    import palette_map_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     load,
    input  pal_set_t pal_d,
    output pal_set_t pal_s
);
    // Capture the whole palette set per fetched tile
    always_ff @(posedge clk) begin
        if (!rst_n)    pal_s <= '0;
        else if (load) pal_s <= pal_d;
    end
endmodule

// File: rtl/shade_lut.sv
// Combinational lookup of the final shade from the working palette copy.
// Object index 0 is transparent and falls back to the background shade.
module shade_lut
    import palette_map_pkg::*;
(
    input  pal_set_t           pal_s,
    input  logic [SHADE_W-1:0] bg_idx,
    input  logic [SHADE_W-1:0] obj_idx,
    input  logic               obj_sel,
    output shade_t             shade,
    output logic               obj_vis
);
    shade_t bg_shade;
    shade_t obj_shade;

    // Per-layer lookups and the layer merge
    always_comb begin
        bg_shade  = field_of(pal_s[SLOT_BG], bg_idx);
        obj_shade = obj_sel ? field_of(pal_s[SLOT_OB1], obj_idx)
                            : field_of(pal_s[SLOT_OB0], obj_idx);
        obj_vis   = |obj_idx;
        shade     = obj_vis ? obj_shade : bg_shade;
    end
endmodule

// File: rtl/palette_map.sv
// Top of the shade mapper: register file, per-tile working copy, lookup.
// Assumes fetch_done pulses once per fetched tile, in the cycle it finishes.
module palette_map
    import palette_map_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter logic [15:0] BASE_ADDR = 16'hFF47
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_wr,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [7:0]        cpu_wdata,
    output logic [7:0]        cpu_rdata,
    input  logic              fetch_done,
    input  logic [1:0]        bg_idx,
    input  logic [1:0]        obj_idx,
    input  logic              obj_pal_sel,
    output logic [1:0]        shade,
    output logic              obj_vis
);
    pal_set_t pal_q;
    pal_set_t pal_s;

    pal_regs #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (cpu_wr),
        .addr  (cpu_addr),
        .wdata (cpu_wdata),
        .rdata (cpu_rdata),
        .pal_q (pal_q)
    );

    pal_snap u_snap (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (fetch_done),
        .pal_d (pal_q),
        .pal_s (pal_s)
    );

    shade_lut u_lut (
        .pal_s   (pal_s),
        .bg_idx  (bg_idx),
        .obj_idx (obj_idx),
        .obj_sel (obj_pal_sel),
        .shade   (shade),
        .obj_vis (obj_vis)
    );
endmodule

// File: rtl/palette_map_chk.sv
// Checker for the shade mapper, attached to every palette_map by bind.
// Observes ports plus the live registers and the working copy.
module palette_map_chk
    import palette_map_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter logic [15:0] BASE_ADDR = 16'hFF47
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_wr,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic [7:0]        cpu_wdata,
    input logic [7:0]        cpu_rdata,
    input logic              fetch_done,
    input logic [1:0]        bg_idx,
    input logic [1:0]        obj_idx,
    input logic              obj_pal_sel,
    input logic [1:0]        shade,
    input logic              obj_vis,
    input pal_set_t          pal_q,
    input pal_set_t          pal_s
);
    localparam logic [ADDR_W-1:0] LO = ADDR_W'(BASE_ADDR);
    localparam logic [ADDR_W-1:0] HI = ADDR_W'(BASE_ADDR) + ADDR_W'(NUM_PAL - 1);

    logic mapped;
    assign mapped = (cpu_addr >= LO) && (cpu_addr <= HI);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (pal_q == '0 && pal_s == '0));

    // R2
    readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && mapped) |=> (cpu_addr != $past(cpu_addr) || cpu_rdata == $past(cpu_wdata)));

    // R3
    unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && !mapped) |=> $stable(pal_q));

    // R5
    shade_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_done |=> (!($stable(bg_idx) && $stable(obj_idx) && $stable(obj_pal_sel)) || $stable(shade)));

    // R6
    snap_old_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_done |=> (pal_s == $past(pal_q)));

    // R7
    transparent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (obj_idx == 2'd0) |-> !obj_vis);

    // R9
    unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mapped |-> (cpu_rdata == 8'h00));
endmodule

bind palette_map palette_map_chk #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_wr      (cpu_wr),
    .cpu_addr    (cpu_addr),
    .cpu_wdata   (cpu_wdata),
    .cpu_rdata   (cpu_rdata),
    .fetch_done  (fetch_done),
    .bg_idx      (bg_idx),
    .obj_idx     (obj_idx),
    .obj_pal_sel (obj_pal_sel),
    .shade       (shade),
    .obj_vis     (obj_vis),
    .pal_q       (pal_q),
    .pal_s       (pal_s)
);

// File: tb/test_palette_map.sv
// Bench for the shade mapper: a behavioural model stepped every clock,
// outputs compared mid-cycle against the model.
module test_palette_map;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [15:0] cpu_addr = 16'h0000;
    logic [7:0]  cpu_wdata = 8'h00;
    logic [7:0]  cpu_rdata;
    logic        fetch_done = 1'b0;
    logic [1:0]  bg_idx = 2'd0;
    logic [1:0]  obj_idx = 2'd0;
    logic        obj_pal_sel = 1'b0;
    logic [1:0]  shade;
    logic        obj_vis;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    string cur_req = "R1";

    // Model state: live registers and the per-tile copy
    int m_reg [3];
    int m_cpy [3];

    always #5 clk = ~clk;

    palette_map i_palette_map (
        .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .fetch_done(fetch_done),
        .bg_idx(bg_idx), .obj_idx(obj_idx), .obj_pal_sel(obj_pal_sel),
        .shade(shade), .obj_vis(obj_vis)
    );

    function automatic int slot_of(input int a);
        if (a >= 'hFF47 && a <= 'hFF49) return a - 'hFF47;
        return -1;
    endfunction

    function automatic int fld(input int pal, input int idx);
        return (pal >> (2 * idx)) & 3;
    endfunction

    task automatic check(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", cur_req, what, act, exp);
        end
    endtask

    // Compare outputs against the model before the coming edge
    task automatic compare();
        int s, e_shade, e_vis, e_rd;
        s = slot_of(cpu_addr);
        e_rd = (s < 0) ? 0 : m_reg[s];
        e_vis = (obj_idx != 0) ? 1 : 0;
        if (e_vis == 1) e_shade = fld(m_cpy[obj_pal_sel ? 2 : 1], obj_idx);
        else            e_shade = fld(m_cpy[0], bg_idx);
        check("rdata", cpu_rdata, e_rd);
        check("shade", shade, e_shade);
        check("obj_vis", obj_vis, e_vis);
    endtask

    // One cycle: drive, compare, clock edge, advance the model
    task automatic step(input bit wr, input int addr, input int data, input bit fd,
                        input int bi, input int oi, input bit sel);
        int s;
        cpu_wr = wr; cpu_addr = addr[15:0]; cpu_wdata = data[7:0];
        fetch_done = fd; bg_idx = bi[1:0]; obj_idx = oi[1:0]; obj_pal_sel = sel;
        #1;
        compare();
        @(posedge clk);
        if (!rst_n) begin
            for (int i = 0; i < 3; i++) begin m_reg[i] = 0; m_cpy[i] = 0; end
        end else begin
            if (fd) for (int i = 0; i < 3; i++) m_cpy[i] = m_reg[i];
            s = slot_of(addr);
            if (wr && s >= 0) m_reg[s] = data & 'hFF;
        end
        @(negedge clk);
    endtask

    task automatic idle(input int bi, input int oi, input bit sel);
        step(1'b0, 'h0000, 0, 1'b0, bi, oi, sel);
    endtask

    task automatic wr_reg(input int addr, input int data);
        step(1'b1, addr, data, 1'b0, 0, 0, 1'b0);
    endtask

    task automatic fetch();
        step(1'b0, 'h0000, 0, 1'b1, 0, 0, 1'b0);
    endtask

    initial begin
        for (int i = 0; i < 3; i++) begin m_reg[i] = 0; m_cpy[i] = 0; end
        @(posedge clk); @(posedge clk); @(negedge clk);

        // R1: reset clears registers and copy, even with a write pending
        cur_req = "R1";
        step(1'b1, 'hFF47, 'hAA, 1'b1, 3, 0, 1'b0);
        step(1'b0, 'hFF47, 0, 1'b0, 3, 0, 1'b0);
        rst_n = 1'b1;
        step(1'b0, 'hFF48, 0, 1'b0, 2, 0, 1'b0);
        step(1'b0, 'hFF49, 0, 1'b0, 1, 3, 1'b1);

        // R2: write each register and read it back
        cur_req = "R2";
        wr_reg('hFF47, 'hE4);
        wr_reg('hFF48, 'h1B);
        wr_reg('hFF49, 'h3D);
        step(1'b0, 'hFF47, 0, 1'b0, 0, 0, 1'b0);
        step(1'b0, 'hFF48, 0, 1'b0, 0, 0, 1'b0);
        step(1'b0, 'hFF49, 0, 1'b0, 0, 0, 1'b0);
        check("R2 ob1 readback", cpu_rdata, 'h3D);

        // R5: no fetch yet, so shades still come from the cleared copy
        cur_req = "R5";
        for (int i = 0; i < 4; i++) idle(i, 0, 1'b0);
        check("R5 shade before fetch", shade, 0);

        // R4: all background indices under two palettes
        cur_req = "R4";
        fetch();
        for (int i = 0; i < 4; i++) idle(i, 0, 1'b0);
        wr_reg('hFF47, 'h3D);
        fetch();
        for (int i = 0; i < 4; i++) idle(i, 0, 1'b0);

        // R8: object indices through both object palettes
        cur_req = "R8";
        for (int i = 1; i < 4; i++) begin idle(0, i, 1'b0); idle(3, i, 1'b1); end

        // R7: transparent index with nonzero field 0 in both object palettes
        cur_req = "R7";
        wr_reg('hFF48, 'hFF);
        wr_reg('hFF49, 'hFE);
        fetch();
        for (int i = 0; i < 4; i++) begin idle(i, 0, 1'b0); idle(i, 0, 1'b1); end

        // R3: unmapped writes change nothing; R9: unmapped reads give zero
        cur_req = "R3";
        wr_reg('hFF46, 'h55);
        wr_reg('hFF4A, 'h55);
        wr_reg('h0047, 'h55);
        fetch();
        for (int i = 0; i < 4; i++) idle(i, 0, 1'b0);
        step(1'b0, 'hFF47, 0, 1'b0, 0, 0, 1'b0);
        cur_req = "R9";
        step(1'b0, 'hFF46, 0, 1'b0, 0, 0, 1'b0);
        step(1'b0, 'hFF4A, 0, 1'b0, 0, 0, 1'b0);
        check("R9 unmapped read", cpu_rdata, 0);

        // R6: write and fetch in the same cycle keep the old palette
        cur_req = "R6";
        wr_reg('hFF47, 'hE4);
        fetch();
        step(1'b1, 'hFF47, 'h1B, 1'b1, 0, 0, 1'b0);
        for (int i = 0; i < 4; i++) idle(i, 0, 1'b0);
        check("R6 old palette idx3", shade, 3);
        fetch();
        for (int i = 0; i < 4; i++) idle(i, 0, 1'b0);

        // R5: mid-line write held off over a tile's worth of cycles
        cur_req = "R5";
        wr_reg('hFF47, 'h00);
        for (int i = 0; i < 6; i++) idle(i % 4, 0, 1'b0);
        fetch();
        for (int i = 0; i < 4; i++) idle(i, 0, 1'b0);

        // Mixed traffic: tiles every 6 cycles, random writes and indices
        cur_req = "R5";
        for (int n = 0; n < 600; n++) begin
            int a;
            a = 'hFF45 + int'($urandom_range(0, 6));
            step(1'($urandom_range(0, 3) == 0), a, int'($urandom_range(0, 255)),
                 (n % 6) == 5, int'($urandom_range(0, 3)), int'($urandom_range(0, 3)),
                 1'($urandom_range(0, 1)));
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run is a failure but still reports
    initial begin
        #1_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule